// File: doc/BRIEF.md
# Dual-Rate Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. It turns bytes into serial frames on its transmit line and rebuilds bytes from frames on its receive line. Every frame has one low start bit, eight data bits sent least significant bit first, and one high stop bit. The line rests high when idle.

A divisor input sets the clock cycles per oversampling tick. A speed-select input sets the ticks per bit: 16 in normal mode, 8 in fast mode. For a given divisor, fast mode therefore doubles the bit rate. The transmit path and the receive path each have their own enable.

A byte enters through a valid/ready handshake. A received byte comes out with a one-cycle valid pulse and a framing-error flag. The divisor and the speed select are meant to change only while both directions are idle.

Top module: `uart_os_top`

## Requirements
- R1: During and right after reset, `txd` is high, `rxValid` is low, and `txReady` equals `cfgTxEn`.
- R2: A transmitted frame drives `txd` low for the start bit, then data bits 0 to 7 in that order, then high for the stop bit. The start bit begins in the cycle after the accepting clock edge.
- R3: Each bit lasts 16×D clock cycles in normal mode (`cfgHighSpeed`=0) and 8×D in fast mode (`cfgHighSpeed`=1). D is `cfgDivisor`, and a divisor of 0 acts as 1.
- R4: A byte is accepted on a clock edge where `txValid` and `txReady` are both high. `txReady` stays low while a frame is being sent.
- R5: While `cfgTxEn` is low, `txReady` is low and no frame starts. Dropping `cfgTxEn` in the middle of a frame lets that whole frame finish.
- R6: A falling edge on `rxd` starts reception, and each bit is sampled at tick 8 of 16 (normal) or tick 4 of 8 (fast). On the stop-bit sample, `rxValid` pulses high for exactly one cycle and `rxData` holds the byte.
- R7: `rxFrameErr` is 1 when the sampled stop bit is low and 0 when it is high. The received byte is delivered in both cases.
- R8: While `cfgRxEn` is low, falling edges on `rxd` do not start reception and produce no `rxValid`.
- R9: If the start bit reads high at its midpoint, the receiver drops the frame without a pulse and waits for the next falling edge.
- R10: With `txd` looped back to `rxd`, every sent byte comes back unchanged with `rxFrameErr`=0, in both speed modes and at several divisors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgDivisor | input | DIV_W | Clock cycles per oversampling tick (0 acts as 1) |
| cfgTxEn | input | 1 | Transmit enable |
| cfgRxEn | input | 1 | Receive enable |
| cfgHighSpeed | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| txData | input | 8 | Byte to send |
| txValid | input | 1 | txData is valid |
| txReady | output | 1 | Transmitter can accept a byte |
| rxData | output | 8 | Last received byte |
| rxValid | output | 1 | One-cycle pulse when a byte is received |
| rxFrameErr | output | 1 | Stop bit of the last received byte was low |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |

## Verification
A wrong bit index or tick count in the transmitter shows on `txd` within one bit time. A bit gets the wrong length or lands in the wrong position, and mid-bit sampling against a bench-computed bit grid catches it. A receiver that samples at the wrong tick or loses count returns a wrong byte or a spurious framing error, one frame later at most, in the loopback vectors. A receiver stuck busy after a glitch, or a frame that wrongly aborts when the enable drops, shows as a missing `rxValid` pulse before the bench timeout.

// File: rtl/uart_os_pkg.sv
package uart_os_pkg;
  localparam int DATA_W     = 8;
  localparam int FRAME_BITS = DATA_W + 2;
  localparam int OS_NORM    = 16;
  localparam int OS_FAST    = 8;
  localparam int SUB_W      = $clog2(OS_NORM);
  localparam int IDX_W      = $clog2(FRAME_BITS);

  // strobes from control to datapath
  typedef struct packed {
    logic txLoad;
    logic txShift;
    logic rxShift;
    logic rxDone;
  } strobe_t;
endpackage

// File: rtl/uart_os_baud.sv
module uart_os_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim  = (divisor == '0) ? '0 : divisor - DIV_W'(1);
  assign tick = !clr && (cnt >= lim);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (clr || tick) cnt <= '0;
    else                  cnt <= cnt + DIV_W'(1);
  end

  // R3: after a clear, the counter restarts from zero
  a_r3_clear_restarts: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (cnt == '0));
endmodule

// File: rtl/uart_os_ctrl.sv
module uart_os_ctrl
  import uart_os_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] cfgDivisor,
  input  logic             cfgTxEn,
  input  logic             cfgRxEn,
  input  logic             cfgHighSpeed,
  input  logic             txValid,
  output logic             txReady,
  input  logic             rxBit,
  output strobe_t          strb
);
  localparam logic [SUB_W-1:0] NORM_LAST = SUB_W'(OS_NORM - 1);
  localparam logic [SUB_W-1:0] FAST_LAST = SUB_W'(OS_FAST - 1);
  localparam logic [SUB_W-1:0] NORM_MID  = SUB_W'(OS_NORM / 2 - 1);
  localparam logic [SUB_W-1:0] FAST_MID  = SUB_W'(OS_FAST / 2 - 1);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_BITS - 1);

  logic [SUB_W-1:0] subLast, subMid;
  assign subLast = cfgHighSpeed ? FAST_LAST : NORM_LAST;
  assign subMid  = cfgHighSpeed ? FAST_MID  : NORM_MID;

  // transmit sequencer
  logic             txBusy, txTick, txBitEnd;
  logic [SUB_W-1:0] txSub;
  logic [IDX_W-1:0] txBitIdx;

  uart_os_baud #(.DIV_W(DIV_W)) txBaud_i (
    .clk(clk), .rstN(rstN), .clr(!txBusy), .divisor(cfgDivisor), .tick(txTick)
  );

  assign txReady  = !txBusy && cfgTxEn;
  assign txBitEnd = txBusy && txTick && (txSub == subLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy   <= 1'b0;
      txSub    <= '0;
      txBitIdx <= '0;
    end else if (txValid && txReady) begin
      txBusy   <= 1'b1;
      txSub    <= '0;
      txBitIdx <= '0;
    end else if (txBusy && txTick) begin
      if (txSub == subLast) begin
        txSub <= '0;
        if (txBitIdx == LAST_IDX) txBusy <= 1'b0;
        else                      txBitIdx <= txBitIdx + IDX_W'(1);
      end else begin
        txSub <= txSub + SUB_W'(1);
      end
    end
  end

  // receive sequencer
  logic             rxBusy, rxTick, rxMid, rxPrev, rxStart;
  logic [SUB_W-1:0] rxSub;
  logic [IDX_W-1:0] rxBitIdx;

  uart_os_baud #(.DIV_W(DIV_W)) rxBaud_i (
    .clk(clk), .rstN(rstN), .clr(!rxBusy), .divisor(cfgDivisor), .tick(rxTick)
  );

  assign rxStart = !rxBusy && cfgRxEn && rxPrev && !rxBit;
  assign rxMid   = rxBusy && rxTick && (rxSub == subMid);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPrev   <= 1'b1;
      rxBusy   <= 1'b0;
      rxSub    <= '0;
      rxBitIdx <= '0;
    end else begin
      rxPrev <= rxBit;
      if (rxStart) begin
        rxBusy   <= 1'b1;
        rxSub    <= '0;
        rxBitIdx <= '0;
      end else if (rxBusy && rxTick) begin
        if (rxMid && rxBitIdx == '0 && rxBit) begin
          rxBusy <= 1'b0;                    // false start
        end else if (rxMid && rxBitIdx == LAST_IDX) begin
          rxBusy <= 1'b0;                    // stop sampled, rearm
        end else if (rxSub == subLast) begin
          rxSub    <= '0;
          rxBitIdx <= rxBitIdx + IDX_W'(1);
        end else begin
          rxSub <= rxSub + SUB_W'(1);
        end
      end
    end
  end

  always_comb begin
    strb.txLoad  = txValid && txReady;
    strb.txShift = txBitEnd;
    strb.rxShift = rxMid && (rxBitIdx != '0) && (rxBitIdx != LAST_IDX);
    strb.rxDone  = rxMid && (rxBitIdx == LAST_IDX);
  end

  // R5: a started frame is not cut short by the enable
  a_r5_frame_runs_on: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && txBitIdx != LAST_IDX) |=> txBusy);
  // R4: after acceptance the handshake closes
  a_r4_ready_drops: assert property (@(posedge clk) disable iff (!rstN)
    strb.txLoad |=> !txReady);
  // R8: a disabled idle receiver stays idle
  a_r8_rx_stays_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgRxEn && !rxBusy) |=> !rxBusy);
  // R6: bit counters stay within the frame
  a_r6_idx_range: assert property (@(posedge clk) disable iff (!rstN)
    (rxBitIdx < IDX_W'(FRAME_BITS)) && (txBitIdx < IDX_W'(FRAME_BITS)));
endmodule

// File: rtl/uart_os_dpath.sv
module uart_os_dpath
  import uart_os_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] txData,
  output logic              txd,
  input  logic              rxd,
  output logic              rxBit,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxFrameErr
);
  logic [FRAME_BITS-1:0] txSh;
  logic [DATA_W-1:0]     rxSh;
  logic                  rxMeta, rxSync;

  assign txd   = txSh[0];
  assign rxBit = rxSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             txSh <= '1;
    else if (strb.txLoad)  txSh <= {1'b1, txData, 1'b0};
    else if (strb.txShift) txSh <= {1'b1, txSh[FRAME_BITS-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta     <= 1'b1;
      rxSync     <= 1'b1;
      rxSh       <= '0;
      rxData     <= '0;
      rxValid    <= 1'b0;
      rxFrameErr <= 1'b0;
    end else begin
      rxMeta  <= rxd;
      rxSync  <= rxMeta;
      rxValid <= strb.rxDone;
      if (strb.rxShift) rxSh <= {rxSync, rxSh[DATA_W-1:1]};
      if (strb.rxDone) begin
        rxData     <= rxSh;
        rxFrameErr <= !rxSync;
      end
    end
  end

  // R2: a load puts the start bit on the line
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rstN)
    strb.txLoad |=> !txd);
  // R2: the line only moves on a load or a bit boundary
  a_r2_line_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.txLoad && !strb.txShift) |=> $stable(txd));
  // R6: the valid pulse lasts one cycle
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
endmodule

// File: rtl/uart_os_top.sv
module uart_os_top
  import uart_os_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  cfgDivisor,
  input  logic              cfgTxEn,
  input  logic              cfgRxEn,
  input  logic              cfgHighSpeed,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxFrameErr,
  output logic              txd,
  input  logic              rxd
);
  strobe_t strb;
  logic    rxBit;

  uart_os_ctrl #(.DIV_W(DIV_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgDivisor(cfgDivisor), .cfgTxEn(cfgTxEn),
    .cfgRxEn(cfgRxEn), .cfgHighSpeed(cfgHighSpeed), .txValid(txValid),
    .txReady(txReady), .rxBit(rxBit), .strb(strb)
  );

  uart_os_dpath dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .txData(txData), .txd(txd),
    .rxd(rxd), .rxBit(rxBit), .rxData(rxData), .rxValid(rxValid),
    .rxFrameErr(rxFrameErr)
  );
endmodule

// File: tb/uart_os_top_tb_top.sv
module uart_os_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cfgDivisor = 16'd2;
  logic        cfgTxEn = 1'b1, cfgRxEn = 1'b1, cfgHighSpeed = 1'b0;
  logic [7:0]  txData = 8'h00;
  logic        txValid = 1'b0;
  logic        txReady, rxValid, rxFrameErr, txd;
  logic [7:0]  rxData;
  logic        loop = 1'b1, rxDrv = 1'b1;
  wire         rxd = loop ? txd : rxDrv;

  int checks = 0, fails = 0, m = 0;
  logic       gotRx = 1'b0, gotErr = 1'b0;
  logic [7:0] gotByte = 8'h00;

  always #5 clk = ~clk;

  uart_os_top dut_i (
    .clk(clk), .rstN(rstN), .cfgDivisor(cfgDivisor), .cfgTxEn(cfgTxEn),
    .cfgRxEn(cfgRxEn), .cfgHighSpeed(cfgHighSpeed), .txData(txData),
    .txValid(txValid), .txReady(txReady), .rxData(rxData), .rxValid(rxValid),
    .rxFrameErr(rxFrameErr), .txd(txd), .rxd(rxd)
  );

  always @(negedge clk) if (rxValid) begin
    gotRx = 1'b1; gotByte = rxData; gotErr = rxFrameErr;
  end

  typedef struct packed { logic [7:0] data; logic hs; logic [15:0] div; } vec_t;
  localparam vec_t VECS [6] = '{
    '{8'hA5, 1'b0, 16'd2}, '{8'h00, 1'b1, 16'd3}, '{8'hFF, 1'b0, 16'd1},
    '{8'h5A, 1'b1, 16'd0}, '{8'h81, 1'b0, 16'd3}, '{8'h7E, 1'b1, 16'd2}};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bitTime(input logic hs, input logic [15:0] div);
    return (hs ? 8 : 16) * ((div == 0) ? 1 : int'(div));
  endfunction

  // returns at the negedge right after the accepting edge (m = 1)
  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    txData = b; txValid = 1'b1;
    while (!txReady) @(negedge clk);
    @(negedge clk);
    txValid = 1'b0;
    m = 1;
  endtask

  task automatic waitTo(input int target);
    while (m < target) begin @(negedge clk); m++; end
  endtask

  task automatic waitRx(input int limit);
    for (int i = 0; i < limit && !gotRx; i++) @(negedge clk);
  endtask

  task automatic sendSerial(input logic [7:0] b, input logic stopBit, input int per);
    for (int k = 0; k < 10; k++) begin
      rxDrv = (k == 0) ? 1'b0 : (k == 9) ? stopBit : b[k-1];
      repeat (per) @(negedge clk);
    end
    rxDrv = 1'b1;
    repeat (per) @(negedge clk);
  endtask

  task automatic measureTx(input logic [7:0] b, input logic hs, input logic [15:0] div);
    int per;
    loop = 1'b0; cfgHighSpeed = hs; cfgDivisor = div;
    per = bitTime(hs, div);
    sendByte(b);
    for (int k = 0; k < 10; k++) begin
      logic e;
      e = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : b[k-1];
      waitTo(k * per + per / 2);
      check(txd == e, "R2/R3 txd bit", txd, e);
    end
    waitTo(10 * per + 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check(txd == 1'b1 && !rxValid && txReady == cfgTxEn, "R1 in reset", txd, 1);
    rstN = 1'b1;
    @(negedge clk);
    check(txd == 1'b1 && !rxValid && txReady, "R1 after reset", {txd, rxValid, txReady}, 3'b101);

    // R10 / R6: loopback vectors
    foreach (VECS[i]) begin
      loop = 1'b1; cfgHighSpeed = VECS[i].hs; cfgDivisor = VECS[i].div;
      gotRx = 1'b0;
      sendByte(VECS[i].data);
      waitRx(12 * bitTime(VECS[i].hs, VECS[i].div));
      check(gotRx && gotByte == VECS[i].data && !gotErr, "R10 loopback byte",
            {gotRx, gotErr, gotByte}, {2'b10, VECS[i].data});
      repeat (4) @(negedge clk);
    end

    // R2 / R3: bit shape and period
    measureTx(8'h4B, 1'b0, 16'd3);
    measureTx(8'hC3, 1'b1, 16'd0);

    // R4: ready low while sending
    cfgDivisor = 16'd1; cfgHighSpeed = 1'b0;
    sendByte(8'h11);
    check(!txReady, "R4 ready while busy", txReady, 0);
    waitTo(10 * 16 + 4);
    check(txReady, "R4 ready after frame", txReady, 1);

    // R5: disabled transmitter
    cfgTxEn = 1'b0;
    @(negedge clk);
    check(!txReady, "R5 ready when disabled", txReady, 0);
    begin
      int lows = 0;
      txValid = 1'b1;
      for (int i = 0; i < 60; i++) begin @(negedge clk); if (!txd) lows++; end
      txValid = 1'b0;
      check(lows == 0, "R5 no frame when disabled", lows, 0);
    end
    cfgTxEn = 1'b1; loop = 1'b1; cfgDivisor = 16'd2; gotRx = 1'b0;
    sendByte(8'h3C);
    waitTo(3 * 32);
    cfgTxEn = 1'b0;
    waitRx(400);
    check(gotRx && gotByte == 8'h3C, "R5 frame finishes after disable", gotByte, 8'h3C);
    repeat (40) @(negedge clk);
    check(!txReady && txd, "R5 idle after finish", {txReady, txd}, 2'b01);
    cfgTxEn = 1'b1;

    // R7: framing error
    loop = 1'b0; cfgDivisor = 16'd2; cfgHighSpeed = 1'b0; gotRx = 1'b0;
    sendSerial(8'h96, 1'b0, 32);
    check(gotRx && gotErr && gotByte == 8'h96, "R7 stop low flagged", {gotErr, gotByte}, 9'h196);
    gotRx = 1'b0;
    sendSerial(8'h69, 1'b1, 32);
    check(gotRx && !gotErr && gotByte == 8'h69, "R7 stop high clean", {gotErr, gotByte}, 9'h069);

    // R8: receiver disabled
    cfgRxEn = 1'b0; gotRx = 1'b0;
    sendSerial(8'h55, 1'b1, 32);
    repeat (40) @(negedge clk);
    check(!gotRx, "R8 no byte while disabled", gotRx, 0);
    cfgRxEn = 1'b1;

    // R9: glitch rejected, then a real frame
    gotRx = 1'b0;
    rxDrv = 1'b0; repeat (2) @(negedge clk); rxDrv = 1'b1;
    repeat (400) @(negedge clk);
    check(!gotRx, "R9 glitch ignored", gotRx, 0);
    cfgHighSpeed = 1'b1;
    sendSerial(8'h81, 1'b1, 16);
    check(gotRx && gotByte == 8'h81 && !gotErr, "R9 receive after glitch", gotByte, 8'h81);

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule